// File: doc/BRIEF.md
# Touch Screen SAR Conversion Sequencer

This block is the digital controller for a 12-bit successive-approximation converter that digitises a resistive touch screen. It runs entirely on an externally supplied serial clock, which serves both as the port clock and as the conversion clock. The host pulls the active-low select low and then streams a control byte on the serial data input. The byte opens with a start bit. The sequencer decodes the byte, drives a one-hot channel select to the analog multiplexer and opens the track/hold window. It then runs a binary search, offering a trial code to an external capacitor DAC and reading back a single comparator bit. Finally it returns the result serially, MSB first, in straight binary.

All timing counts serial-clock edges from the rising edge that sampled the start bit (edge zero). The falling edges that follow are numbered one upward. The serial output and the busy flag go to pad drivers through separate enable outputs, and both enables follow the select line. The block can convert at 12 or 8 bits, and the mode is chosen per transaction.

Top module: `tsadc_seq`

## Requirements
- R1: While `cs_n` is high, `sdo_en` and `busy_en` are 0. Reset and a high `cs_n` both force `busy`, `sample`, `sdo`, `ch_sel` and `dac_code` to 0.
- R2: `din` is sampled on rising `sclk` edges. Zeros before the first 1 are ignored, and the first 1 sampled is the start bit, which opens the transaction.
- R3: The seven bits that follow the start bit are, in order: a channel-disable bit, two channel-address bits (high first), a resolution bit (1 = 8-bit), a differential bit and two power-mode bits (high first). `diff_mode` and `pwr_mode` show the captured values.
- R4: From the third rising edge after the start bit until the transaction ends, `ch_sel` is one-hot at the index given by the address bits, or all zero when the channel-disable bit is 1. It holds steady throughout.
- R5: `sample` rises on the fifth falling edge after the start bit and falls on the eighth, an acquisition window of three clock cycles. It is never high together with `busy`.
- R6: `busy` rises on the eighth falling edge and falls on falling edge 8+N, where N is 12 or 8 per the resolution bit.
- R7: After the seventh rising edge, `dac_code` shows only the MSB set. Each of the next N rising edges makes one decision: the bit under trial is kept when `comp` is 1 (input at or above the trial code). Lower bits stay 0 in 8-bit mode.
- R8: On falling edges 8+N through 7+2N, `sdo` presents the N-bit straight-binary result, MSB first. With an ideal comparator this equals the input code, truncated to its top 8 bits in 8-bit mode.
- R9: After the last result bit, `sdo` is 0 and the sequencer hunts for a new start bit without `cs_n` having to rise.
- R10: A rise of `cs_n` mid-transaction aborts it at once. Clock edges while `cs_n` is high are ignored, and the next transaction starts cleanly.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| sclk | input | 1 | Serial clock, also the conversion clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low select; high aborts and clears |
| din | input | 1 | Serial control input, sampled on rising edges |
| comp | input | 1 | Comparator: 1 when input >= trial code |
| sdo | output | 1 | Serial result, changes on falling edges |
| sdo_en | output | 1 | Pad drive enable for `sdo` |
| busy | output | 1 | High while the conversion runs |
| busy_en | output | 1 | Pad drive enable for `busy` |
| sample | output | 1 | Track/hold acquisition window |
| ch_sel | output | 4 | One-hot input-multiplexer select |
| dac_code | output | 12 | Trial code to the capacitor DAC |
| diff_mode | output | 1 | Captured differential bit |
| pwr_mode | output | 2 | Captured power-mode bits |

## Verification
The bench builds the block with its default parameters: 12-bit full resolution and an 8-bit reduced mode. Because the resolution is a per-transaction control bit, both edge schedules are reachable in one build: busy falls on edge 20 or 16, and the result stream is 12 or 8 bits long. The comparator model makes every trial code from all-zeros to all-ones reachable. Back-to-back transactions exercise the return to start-bit hunting, and an abort in mid-conversion exercises the select-driven clear.

// File: rtl/tsadc_pkg.sv
package tsadc_pkg;
  // control field positions inside the captured byte (after the start bit)
  localparam int CTRL_W    = 7;
  localparam int F_CH_OFF  = 6;
  localparam int F_ADDR_HI = 5;
  localparam int F_ADDR_LO = 4;
  localparam int F_LORES   = 3;
  localparam int F_DIFF    = 2;
  localparam int F_PWR_HI  = 1;
  localparam int F_PWR_LO  = 0;

  localparam int CH_N      = 4;
  localparam int ADDR_W    = $clog2(CH_N);

  // edge schedule, as the count seen after rising edge k
  localparam int ADDR_DONE = 3;  // address bits complete
  localparam int ACQ_OPEN  = 4;  // seen at falling edge 5
  localparam int ACQ_CLOSE = 7;  // seen at falling edge 8
endpackage

// File: rtl/tsadc_rx.sv
module tsadc_rx
  import tsadc_pkg::*;
#(
  parameter int RES    = 12,
  parameter int LO_RES = 8,
  parameter int CW     = 5
) (
  input  logic              sclk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              din,
  output logic              active,
  output logic [CW-1:0]     cnt,
  output logic [CTRL_W-1:0] ctrl
);
  localparam int LAST_HI = ACQ_CLOSE + 2*RES - 1;
  localparam int LAST_LO = ACQ_CLOSE + 2*LO_RES - 1;

  logic              active_q, active_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic [CW-1:0]     last_cnt;

  assign last_cnt = ctrl_q[F_LORES] ? CW'(LAST_LO) : CW'(LAST_HI);

  always_comb begin
    active_d = active_q;
    cnt_d    = cnt_q;
    ctrl_d   = ctrl_q;
    if (!active_q) begin
      if (din) begin
        active_d = 1'b1;
        cnt_d    = '0;
        ctrl_d   = '0;
      end
    end else if (cnt_q == last_cnt) begin
      active_d = 1'b0;
      cnt_d    = '0;
    end else begin
      cnt_d = cnt_q + 1'b1;
      for (int i = 0; i < CTRL_W; i++) begin
        if (cnt_d == CW'(CTRL_W - i)) ctrl_d[i] = din;
      end
    end
  end

  always_ff @(posedge sclk or negedge rst_n or posedge cs_n) begin
    if (!rst_n || cs_n) begin
      active_q <= 1'b0;
      cnt_q    <= '0;
      ctrl_q   <= '0;
    end else begin
      active_q <= active_d;
      cnt_q    <= cnt_d;
      ctrl_q   <= ctrl_d;
    end
  end

  assign active = active_q;
  assign cnt    = cnt_q;
  assign ctrl   = ctrl_q;

  AST_START_ON_ONE: assert property (@(posedge sclk) disable iff (!rst_n || cs_n)
    $rose(active_q) |-> (cnt_q == '0) && $past(din)); // R2

  AST_CNT_BOUND: assert property (@(posedge sclk) disable iff (!rst_n || cs_n)
    active_q |-> (cnt_q <= CW'(LAST_HI))); // R9
endmodule

// File: rtl/tsadc_sar.sv
module tsadc_sar
  import tsadc_pkg::*;
#(
  parameter int RES    = 12,
  parameter int LO_RES = 8,
  parameter int CW     = 5
) (
  input  logic           sclk,
  input  logic           rst_n,
  input  logic           cs_n,
  input  logic           active,
  input  logic [CW-1:0]  cnt,
  input  logic           lo_res,
  input  logic           comp,
  output logic [RES-1:0] result,
  output logic [RES-1:0] dac_code
);
  localparam int INIT_CNT = ACQ_CLOSE - 1;

  logic [RES-1:0] sar_q, sar_d;
  logic [RES-1:0] mask_q, mask_d;

  always_comb begin
    sar_d  = sar_q;
    mask_d = mask_q;
    if (!active) begin
      mask_d = '0;
    end else if (cnt == CW'(INIT_CNT)) begin
      sar_d  = '0;
      mask_d = {1'b1, {(RES-1){1'b0}}};
    end else if (|mask_q) begin
      if (comp) sar_d = sar_q | mask_q;
      mask_d = (lo_res && mask_q[RES-LO_RES]) ? '0 : (mask_q >> 1);
    end
  end

  always_ff @(posedge sclk or negedge rst_n or posedge cs_n) begin
    if (!rst_n || cs_n) begin
      sar_q  <= '0;
      mask_q <= '0;
    end else begin
      sar_q  <= sar_d;
      mask_q <= mask_d;
    end
  end

  assign result   = sar_q;
  assign dac_code = sar_q | mask_q;

  AST_ONE_TRIAL_BIT: assert property (@(posedge sclk) disable iff (!rst_n || cs_n)
    $onehot0(mask_q)); // R7

  AST_LOW_BITS_IDLE_LORES: assert property (@(posedge sclk) disable iff (!rst_n || cs_n)
    (lo_res && (cnt > CW'(ACQ_CLOSE))) |-> (sar_q[RES-LO_RES-1:0] == '0)); // R7
endmodule

// File: rtl/tsadc_tx.sv
module tsadc_tx
  import tsadc_pkg::*;
#(
  parameter int RES    = 12,
  parameter int LO_RES = 8,
  parameter int CW     = 5
) (
  input  logic           sclk,
  input  logic           rst_n,
  input  logic           cs_n,
  input  logic           active,
  input  logic [CW-1:0]  cnt,
  input  logic           lo_res,
  input  logic [RES-1:0] result,
  output logic           busy,
  output logic           sample,
  output logic           sdo
);
  logic           busy_q, busy_d;
  logic           sample_q, sample_d;
  logic [RES-1:0] osr_q, osr_d;
  logic [CW-1:0]  conv_end;

  assign conv_end = lo_res ? CW'(ACQ_CLOSE + LO_RES) : CW'(ACQ_CLOSE + RES);

  always_comb begin
    sample_d = sample_q;
    busy_d   = busy_q;
    osr_d    = osr_q << 1;
    if (!active) begin
      sample_d = 1'b0;
      busy_d   = 1'b0;
      osr_d    = '0;
    end else begin
      if (cnt == CW'(ACQ_OPEN))  sample_d = 1'b1;
      if (cnt == CW'(ACQ_CLOSE)) begin
        sample_d = 1'b0;
        busy_d   = 1'b1;
      end
      if (cnt == conv_end) begin
        busy_d = 1'b0;
        osr_d  = result;
      end
    end
  end

  always_ff @(negedge sclk or negedge rst_n or posedge cs_n) begin
    if (!rst_n || cs_n) begin
      busy_q   <= 1'b0;
      sample_q <= 1'b0;
      osr_q    <= '0;
    end else begin
      busy_q   <= busy_d;
      sample_q <= sample_d;
      osr_q    <= osr_d;
    end
  end

  assign busy   = busy_q;
  assign sample = sample_q;
  assign sdo    = osr_q[RES-1];

  AST_ACQ_BUSY_EXCL: assert property (@(negedge sclk) disable iff (!rst_n || cs_n)
    !(sample_q && busy_q)); // R5

  AST_BUSY_AFTER_ACQ: assert property (@(negedge sclk) disable iff (!rst_n || cs_n)
    $rose(busy_q) |-> $past(sample_q)); // R6

  AST_BUSY_IN_TXN: assert property (@(negedge sclk) disable iff (!rst_n || cs_n)
    busy_q |-> active); // R6
endmodule

// File: rtl/tsadc_seq.sv
module tsadc_seq
  import tsadc_pkg::*;
#(
  parameter int RES    = 12,
  parameter int LO_RES = 8
) (
  input  logic            sclk,
  input  logic            rst_n,
  input  logic            cs_n,
  input  logic            din,
  input  logic            comp,
  output logic            sdo,
  output logic            sdo_en,
  output logic            busy,
  output logic            busy_en,
  output logic            sample,
  output logic [CH_N-1:0] ch_sel,
  output logic [RES-1:0]  dac_code,
  output logic            diff_mode,
  output logic [1:0]      pwr_mode
);
  localparam int CW = $clog2(ACQ_CLOSE + 2*RES + 1);

  logic              active;
  logic [CW-1:0]     cnt;
  logic [CTRL_W-1:0] ctrl;
  logic [RES-1:0]    result;
  logic              ch_ok;

  tsadc_rx #(.RES(RES), .LO_RES(LO_RES), .CW(CW)) u_rx (
    .sclk(sclk), .rst_n(rst_n), .cs_n(cs_n), .din(din),
    .active(active), .cnt(cnt), .ctrl(ctrl)
  );

  tsadc_sar #(.RES(RES), .LO_RES(LO_RES), .CW(CW)) u_sar (
    .sclk(sclk), .rst_n(rst_n), .cs_n(cs_n), .active(active), .cnt(cnt),
    .lo_res(ctrl[F_LORES]), .comp(comp), .result(result), .dac_code(dac_code)
  );

  tsadc_tx #(.RES(RES), .LO_RES(LO_RES), .CW(CW)) u_tx (
    .sclk(sclk), .rst_n(rst_n), .cs_n(cs_n), .active(active), .cnt(cnt),
    .lo_res(ctrl[F_LORES]), .result(result),
    .busy(busy), .sample(sample), .sdo(sdo)
  );

  assign ch_ok = active && (cnt >= CW'(ADDR_DONE)) && !ctrl[F_CH_OFF];

  for (genvar g = 0; g < CH_N; g++) begin : g_chdec
    assign ch_sel[g] = ch_ok && (ctrl[F_ADDR_HI:F_ADDR_LO] == ADDR_W'(g));
  end

  assign sdo_en    = !cs_n;
  assign busy_en   = !cs_n;
  assign diff_mode = ctrl[F_DIFF];
  assign pwr_mode  = ctrl[F_PWR_HI:F_PWR_LO];

  AST_CHSEL_STEADY: assert property (@(posedge sclk) disable iff (!rst_n || cs_n)
    ((|ch_sel) && active) |=> (!active || (ch_sel == $past(ch_sel)))); // R4

  AST_NO_BUSY_IDLE: assert property (@(posedge sclk) disable iff (!rst_n || cs_n)
    !active |=> !sample); // R5
endmodule

// File: tb/tsadc_seq_tb.sv
module tsadc_seq_tb;
  localparam int CLK_PERIOD = 20;
  localparam int RES = 12;

  logic sclk, rst_n, cs_n, din, comp;
  logic sdo, sdo_en, busy, busy_en, sample, diff_mode;
  logic [3:0] ch_sel;
  logic [RES-1:0] dac_code, vin;
  logic [1:0] pwr_mode;
  int n_tests, n_fail;

  assign comp = (vin >= dac_code);

  tsadc_seq u_dut (
    .sclk(sclk), .rst_n(rst_n), .cs_n(cs_n), .din(din), .comp(comp),
    .sdo(sdo), .sdo_en(sdo_en), .busy(busy), .busy_en(busy_en),
    .sample(sample), .ch_sel(ch_sel), .dac_code(dac_code),
    .diff_mode(diff_mode), .pwr_mode(pwr_mode)
  );

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // one serial clock: din set while low, rise, fall, return a quarter after fall
  task automatic clk_cycle(input logic d);
    din = d;
    #(CLK_PERIOD/4); sclk = 1'b1;
    #(CLK_PERIOD/2); sclk = 1'b0;
    #(CLK_PERIOD/4);
  endtask

  function automatic logic [3:0] exp_ch(input logic off, input logic [1:0] a);
    return off ? 4'b0 : (4'b1 << a);
  endfunction

  function automatic int exp_result(input logic lo, input logic [RES-1:0] v);
    return lo ? int'(v >> 4) : int'(v);
  endfunction

  task automatic run(input logic lo, input logic off, input logic [1:0] a,
                     input logic dif, input logic [1:0] pm,
                     input logic [RES-1:0] v, input int nz);
    logic [7:0] bits;
    int n, got;
    vin = v; cs_n = 1'b0;
    bits = {1'b1, off, a, lo, dif, pm};
    n = lo ? 8 : 12;
    got = 0;
    for (int z = 0; z < nz; z++) begin
      clk_cycle(1'b0);
      chk(!busy && !sample && ch_sel == 0, "R2 zeros before start ignored", int'(busy), 0);
    end
    for (int j = 0; j <= 7 + 2*n; j++) begin
      clk_cycle(j < 8 ? bits[7-j] : 1'b0);
      chk(sample == (j >= 4 && j <= 6), "R5 acquisition window", int'(sample), int'(j >= 4 && j <= 6));
      chk(busy == (j >= 7 && j <= 6 + n), "R6 busy timing", int'(busy), int'(j >= 7 && j <= 6 + n));
      if (j == 3 || j == 6 + 2*n)
        chk(ch_sel == exp_ch(off, a), "R4 channel select", int'(ch_sel), int'(exp_ch(off, a)));
      if (j == 7)
        chk(dac_code == 12'h800, "R7 first trial code", int'(dac_code), 'h800);
      if (j == 7 + n)
        chk(dac_code == (lo ? (v & 12'hFF0) : v), "R7 final code", int'(dac_code),
            int'(lo ? (v & 12'hFF0) : v));
      if (j >= 7 + n && j <= 6 + 2*n) got = (got << 1) | int'(sdo);
      if (j == 7 + 2*n)
        chk(!sdo && !busy && ch_sel == 0, "R9 idle after result", int'(sdo), 0);
    end
    chk(got == exp_result(lo, v), "R8 serial result", got, exp_result(lo, v));
    chk(diff_mode == dif && pwr_mode == pm, "R3 captured fields",
        int'({diff_mode, pwr_mode}), int'({dif, pm}));
    chk(sdo_en && busy_en, "R1 enables with select low", int'({sdo_en, busy_en}), 3);
  endtask

  task automatic release_cs();
    cs_n = 1'b1;
    #(CLK_PERIOD/8);
    chk(!sdo_en && !busy_en, "R1 enables off with select high", int'({sdo_en, busy_en}), 0);
    #(CLK_PERIOD/8);
  endtask

  initial begin
    #(CLK_PERIOD * 100000);
    n_fail++;
    $display("FAIL watchdog R1 actual=timeout expected=finish");
    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    int seed;
    n_tests = 0; n_fail = 0;
    sclk = 1'b0; din = 1'b0; cs_n = 1'b0; vin = '0; rst_n = 1'b0;
    seed = int'($urandom(32'h5EED_1234));
    #(CLK_PERIOD);
    chk(!busy && !sample && !sdo && ch_sel == 0 && dac_code == 0, "R1 reset state",
        int'(dac_code), 0);
    cs_n = 1'b1;
    #(CLK_PERIOD);
    rst_n = 1'b1;
    #(CLK_PERIOD);

    // directed corners, both resolutions
    run(1'b0, 1'b0, 2'd0, 1'b0, 2'd0, 12'h000, 0); release_cs();
    run(1'b0, 1'b0, 2'd3, 1'b1, 2'd3, 12'hFFF, 2); release_cs();
    run(1'b0, 1'b0, 2'd1, 1'b0, 2'd2, 12'h800, 1); release_cs();
    run(1'b0, 1'b1, 2'd2, 1'b1, 2'd1, 12'h7FF, 0); release_cs();
    run(1'b1, 1'b0, 2'd2, 1'b0, 2'd1, 12'hFFF, 3); release_cs();
    run(1'b1, 1'b0, 2'd1, 1'b1, 2'd0, 12'h00F, 0); release_cs();
    // back to back without releasing select (R9)
    run(1'b1, 1'b0, 2'd0, 1'b0, 2'd0, 12'hA5C, 0);
    run(1'b0, 1'b0, 2'd3, 1'b1, 2'd2, 12'h3C7, 1);
    release_cs();

    // abort in mid conversion (R10)
    cs_n = 1'b0; vin = 12'h9AB;
    for (int j = 0; j < 12; j++) clk_cycle(j == 0 ? 1'b1 : 1'b0);
    chk(busy == 1'b1, "R10 busy before abort", int'(busy), 1);
    cs_n = 1'b1;
    #(CLK_PERIOD/8);
    chk(!busy_en && !sdo_en, "R10 enables off on abort", int'({busy_en, sdo_en}), 0);
    for (int j = 0; j < 3; j++) clk_cycle(1'b1);
    cs_n = 1'b0;
    #(CLK_PERIOD/8);
    chk(!busy && !sample && ch_sel == 0 && dac_code == 0, "R10 cleared after abort",
        int'(dac_code), 0);
    run(1'b0, 1'b0, 2'd2, 1'b0, 2'd3, 12'h9AB, 0); release_cs();

    // constrained random transactions
    for (int k = 0; k < 40; k++) begin
      logic [RES-1:0] rv;
      logic [2:0] ra;
      rv = RES'($urandom);
      ra = 3'($urandom);
      run(1'($urandom), ra[2], ra[1:0], 1'($urandom), 2'($urandom), rv,
          int'($urandom_range(0, 3)));
      if (($urandom & 1) == 0) release_cs();
    end
    release_cs();

    $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule